// File: doc/BRIEF.md
# Packet-Driven Memory Write Engine

This block turns request packets into bus writes. A request arrives as a byte packet on a valid/ready input stream. The packet opens with a fixed eight-byte header. That header holds an operation code, a spare byte, a byte count and a start address. For a write, the rest of the packet is payload. The engine writes each payload byte to the bus, one byte-enabled write per byte. When the request is finished, it returns a four-byte response packet on a valid/ready output stream. The response states how many bytes were actually written.

Both streams follow the usual rules. A byte moves only in a cycle where valid and ready are both high. The engine accepts no request bytes while a bus write is outstanding or while a response is waiting to be taken. While it holds a response byte under back-pressure, that byte and its framing flags do not change. On the bus side, the engine holds a write steady for as long as the slave stalls it with waitrequest.

Top module: `pkt_txn_engine`

## Requirements
- R1: After reset the engine accepts input (`in_ready` = 1) with no write and no response pending. Header byte 0 is the operation code. Byte 1 is spare and its value has no effect. Bytes 2-3 are the byte count, most significant byte first. Bytes 4-7 are the start address, most significant byte first.
- R2: Operation code 0x00 is a write. Payload byte i of the packet is written to byte address start+i, in packet order, with exactly one bus write per byte.
- R3: Each bus write drives the byte address with its two low bits cleared on `bus_address`. It drives a one-hot `bus_byteenable` with bit n set, where n is the two low address bits. The payload byte is copied into every byte lane of `bus_writedata`.
- R4: While `bus_write` and `bus_waitrequest` are both high, the write, address, enables and data hold unchanged. A write completes in the first cycle where `bus_waitrequest` is low. No further request byte is accepted until then.
- R5: Every request is answered by a response packet of exactly four bytes. `out_sop` is set on the first byte and `out_eop` on the fourth. The bytes are: operation code OR 0x80, then 0x00, then the written byte count as two bytes, most significant first.
- R6: If the packet ends before the byte count is reached, the write stops. This includes a packet that ends inside the header. The response then carries the number of bytes actually written.
- R7: Payload bytes beyond the byte count are taken and discarded without bus access. The response is sent after end-of-packet and carries a count equal to the byte count.
- R8: A request with any operation code other than 0x00 causes no bus write. The rest of its packet is discarded, and it is answered with a count of zero.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold. `in_ready` stays low while a response byte is pending.
- R10: An accepted input byte with `in_sop` set is always taken as header byte 0, even if an earlier header was left incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Engine can take a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | First byte of a request packet |
| in_eop | input | 1 | Last byte of a request packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Downstream can take a response byte |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | First byte of the response |
| out_eop | output | 1 | Last byte of the response |
| bus_address | output | 32 | Word-aligned write address |
| bus_write | output | 1 | Write request |
| bus_byteenable | output | 4 | Byte lane select |
| bus_writedata | output | 32 | Write data, byte copied to all lanes |
| bus_waitrequest | input | 1 | Slave stall |

## Verification
The coincidence that matters is the final payload byte. When it carries end-of-packet and also reaches the byte count, both ways of ending a write fire on the same byte. The test sends packets whose last byte does exactly this, first with no stalls and then with waitrequest stretching that last write. It also throttles `out_ready` at the same time. The engine must not stop in the discard state or send a second response. The count must equal the length that was sent, and the response must appear only after the stalled write completes.

// File: rtl/pkt_txn_pkg.sv
package pkt_txn_pkg;
  localparam logic [7:0] OP_WRITE  = 8'h00;
  localparam logic [7:0] RESP_MARK = 8'h80;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_PAY,
    ST_WAIT,
    ST_DRAIN,
    ST_RESP
  } eng_state_t;
endpackage

// File: rtl/pkt_hdr_capture.sv
module pkt_hdr_capture #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic              clr,
  input  logic [7:0]        data,
  output logic [7:0]        cmd_o,
  output logic [7:0]        cmd_now_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int SIZE_B  = SIZE_W / 8;
  localparam int ADDR_B  = ADDR_W / 8;
  localparam int SIZE_LO = 2;
  localparam int ADDR_LO = SIZE_LO + SIZE_B;
  localparam int HDR_B   = ADDR_LO + ADDR_B;
  localparam int IDX_W   = $clog2(HDR_B + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  eff_idx;
  logic [7:0]        cmd_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;

  // a start-of-packet marker always re-aligns the header to byte 0
  assign eff_idx   = restart ? '0 : idx_q;
  assign last_o    = take && (int'(eff_idx) == HDR_B - 1);
  assign cmd_now_o = (eff_idx == '0) ? data : cmd_q;
  assign cmd_o     = cmd_q;
  assign size_o    = size_q;
  assign addr_o    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cmd_q  <= '0;
      size_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      if (clr || last_o) idx_q <= '0;
      else               idx_q <= eff_idx + 1'b1;
      if (eff_idx == '0) cmd_q <= data;
      if (int'(eff_idx) >= SIZE_LO && int'(eff_idx) < ADDR_LO)
        size_q <= {size_q[SIZE_W-9:0], data};
      if (int'(eff_idx) >= ADDR_LO && int'(eff_idx) < HDR_B)
        addr_q <= {addr_q[ADDR_W-9:0], data};
    end
  end

  assert_idx_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < HDR_B);
  assert_restart_to_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && restart && !clr) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/pkt_bus_writer.sv
module pkt_bus_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          byte_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [ADDR_W-1:0]   bus_address,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_byteenable,
  output logic [DATA_W-1:0]   bus_writedata,
  input  logic                bus_waitrequest,
  output logic                done_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              wr_q;
  logic [7:0]        byte_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      byte_q <= '0;
      addr_q <= '0;
    end else if (start) begin
      wr_q   <= 1'b1;
      byte_q <= byte_i;
      addr_q <= addr_i;
    end else if (wr_q && !bus_waitrequest) begin
      wr_q <= 1'b0;
    end
  end

  assign bus_write     = wr_q;
  assign done_o        = wr_q && !bus_waitrequest;
  assign bus_writedata = {LANES{byte_q}};

  generate
    if (LANES > 1) begin : g_multi_lane
      logic [LANE_W-1:0] lane;
      assign lane           = addr_q[LANE_W-1:0];
      assign bus_address    = {addr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      assign bus_byteenable = wr_q ? (LANES'(1) << lane) : '0;
    end else begin : g_single_lane
      assign bus_address    = addr_q;
      assign bus_byteenable = wr_q;
    end
  endgenerate

  assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_waitrequest) |=> (bus_write && $stable(bus_address) &&
      $stable(bus_writedata) && $stable(bus_byteenable)));
  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> ($countones(bus_byteenable) == 1));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wr_q);
endmodule

// File: rtl/pkt_resp_gen.sv
module pkt_resp_gen #(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cmd,
  input  logic [SIZE_W-1:0] count,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              done_o
);
  import pkt_txn_pkg::*;

  localparam int RESP_B = 2 + SIZE_W / 8;
  localparam int RESP_W = RESP_B * 8;
  localparam int IDX_W  = $clog2(RESP_B);

  logic              valid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RESP_W-1:0] buf_q;
  logic              take;

  assign take      = valid_q && out_ready;
  assign out_valid = valid_q;
  assign out_data  = buf_q[RESP_W-1 -: 8];
  assign out_sop   = valid_q && (idx_q == '0);
  assign out_eop   = valid_q && (int'(idx_q) == RESP_B - 1);
  assign done_o    = take && out_eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      buf_q   <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
      buf_q   <= {cmd | RESP_MARK, 8'h00, count};
    end else if (take) begin
      buf_q <= {buf_q[RESP_W-9:0], 8'h00};
      if (out_eop) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_hold_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_sop) && $stable(out_eop)));
  assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !valid_q);
endmodule

// File: rtl/pkt_txn_engine.sv
module pkt_txn_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  input  logic                in_sop,
  input  logic                in_eop,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_data,
  output logic                out_sop,
  output logic                out_eop,
  output logic [ADDR_W-1:0]   bus_address,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_byteenable,
  output logic [DATA_W-1:0]   bus_writedata,
  input  logic                bus_waitrequest
);
  import pkt_txn_pkg::*;

  eng_state_t        st_q, st_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              eop_q, eop_d;
  logic              acc;
  logic              hdr_take, hdr_last;
  logic [7:0]        cmd_q, cmd_now;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q;
  logic              wr_start, wr_done;
  logic              resp_start, resp_done;
  logic [7:0]        resp_cmd;
  logic [SIZE_W-1:0] resp_cnt;
  logic [SIZE_W-1:0] cnt_inc;

  assign in_ready = (st_q == ST_HDR) || (st_q == ST_PAY) || (st_q == ST_DRAIN);
  assign acc      = in_valid && in_ready;
  assign hdr_take = acc && (st_q == ST_HDR);
  assign wr_start = acc && (st_q == ST_PAY);
  assign cnt_inc  = cnt_q + 1'b1;

  pkt_hdr_capture #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) hdr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (hdr_take),
    .restart  (in_sop),
    .clr      (in_eop),
    .data     (in_data),
    .cmd_o    (cmd_q),
    .cmd_now_o(cmd_now),
    .size_o   (size_q),
    .addr_o   (base_q),
    .last_o   (hdr_last)
  );

  pkt_bus_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wr_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (wr_start),
    .byte_i         (in_data),
    .addr_i         (base_q + ADDR_W'(cnt_q)),
    .bus_address    (bus_address),
    .bus_write      (bus_write),
    .bus_byteenable (bus_byteenable),
    .bus_writedata  (bus_writedata),
    .bus_waitrequest(bus_waitrequest),
    .done_o         (wr_done)
  );

  pkt_resp_gen #(.SIZE_W(SIZE_W)) resp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (resp_start),
    .cmd      (resp_cmd),
    .count    (resp_cnt),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .done_o   (resp_done)
  );

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    eop_d      = eop_q;
    resp_start = 1'b0;
    resp_cmd   = cmd_q;
    resp_cnt   = cnt_q;
    unique case (st_q)
      ST_HDR: begin
        if (hdr_take) begin
          if (in_eop) begin
            // packet closed inside the header: nothing written
            resp_start = 1'b1;
            resp_cmd   = cmd_now;
            resp_cnt   = '0;
            st_d       = ST_RESP;
          end else if (hdr_last) begin
            st_d = (cmd_now == OP_WRITE && size_q != '0) ? ST_PAY : ST_DRAIN;
          end
        end
      end
      ST_PAY: begin
        if (acc) begin
          eop_d = in_eop;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wr_done) begin
          cnt_d = cnt_inc;
          if (eop_q) begin
            resp_start = 1'b1;
            resp_cnt   = cnt_inc;
            st_d       = ST_RESP;
          end else if (cnt_inc == size_q) begin
            st_d = ST_DRAIN;
          end else begin
            st_d = ST_PAY;
          end
        end
      end
      ST_DRAIN: begin
        if (acc && in_eop) begin
          resp_start = 1'b1;
          st_d       = ST_RESP;
        end
      end
      ST_RESP: begin
        if (resp_done) begin
          cnt_d = '0;
          st_d  = ST_HDR;
        end
      end
      default: st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HDR;
      cnt_q <= '0;
      eop_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      eop_q <= eop_d;
    end
  end

  assert_count_below_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY || st_q == ST_WAIT) |-> (cnt_q < size_q));
  assert_no_bus_while_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> !bus_write);
  assert_input_closed_in_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_input_closed_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> !in_ready);
  assert_write_needs_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_write) |-> (cmd_q == OP_WRITE));
endmodule

// File: tb/pkt_txn_engine_tb_top.sv
module pkt_txn_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid, out_sop, out_eop;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [31:0] bus_address, bus_writedata;
  logic        bus_write;
  logic [3:0]  bus_byteenable;
  logic        bus_waitrequest = 1'b0;

  int checks = 0, fails = 0;
  int wait_cfg = 0, rdy_mode = 0, cyc = 0, stall = 0;
  logic        prev_stall = 1'b0, prev_hold = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [7:0]  prev_data = '0;

  logic [31:0] w_addr[$];
  logic [3:0]  w_be[$];
  logic [31:0] w_data[$];
  logic [7:0]  r_byte[$];
  logic        r_sop[$], r_eop[$];
  logic [7:0]  pkt_q[$];
  logic [7:0]  pay_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_txn_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .bus_address(bus_address), .bus_write(bus_write),
    .bus_byteenable(bus_byteenable), .bus_writedata(bus_writedata),
    .bus_waitrequest(bus_waitrequest)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus slave model: decides the stall for the coming edge, records completed writes
  always @(negedge clk) begin
    if (prev_stall) begin
      chk("R4", "write held under stall", {31'd0, bus_write}, 32'd1);
      chk("R4", "address held under stall", bus_address, prev_addr);
    end
    if (bus_write) begin
      if (stall < wait_cfg) begin
        bus_waitrequest = 1'b1;
        stall++;
        prev_stall = 1'b1;
        prev_addr  = bus_address;
      end else begin
        bus_waitrequest = 1'b0;
        stall = 0;
        prev_stall = 1'b0;
        w_addr.push_back(bus_address);
        w_be.push_back(bus_byteenable);
        w_data.push_back(bus_writedata);
      end
    end else begin
      bus_waitrequest = 1'b0;
      prev_stall = 1'b0;
    end
  end

  // response sink with optional throttling
  always @(negedge clk) begin
    cyc++;
    if (prev_hold) begin
      chk("R9", "response byte held", {24'd0, out_data}, {24'd0, prev_data});
      chk("R9", "valid held", {31'd0, out_valid}, 32'd1);
    end
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (out_valid && in_ready) chk("R9", "input closed during response", 32'd1, 32'd0);
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    if (out_valid && out_ready) begin
      r_byte.push_back(out_data);
      r_sop.push_back(out_sop);
      r_eop.push_back(out_eop);
    end
  end

  task automatic build_hdr(logic [7:0] cmd, logic [7:0] rsv, logic [15:0] size, logic [31:0] addr);
    pkt_q = {cmd, rsv, size[15:8], size[7:0], addr[31:24], addr[23:16], addr[15:8], addr[7:0]};
  endtask

  task automatic add_payload(int n, logic [7:0] seed);
    pay_q = {};
    for (int i = 0; i < n; i++) begin
      pay_q.push_back(seed + 8'(i * 37));
      pkt_q.push_back(seed + 8'(i * 37));
    end
  endtask

  task automatic send_pkt(bit with_sop, bit with_eop);
    for (int i = 0; i < pkt_q.size(); i++) begin
      in_valid = 1'b1;
      in_data  = pkt_q[i];
      in_sop   = with_sop && (i == 0);
      in_eop   = with_eop && (i == pkt_q.size() - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
    end
  endtask

  task automatic expect_resp(string req, logic [7:0] cmd, logic [15:0] cnt);
    int t = 0;
    while (r_byte.size() < 4 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    chk(req, "response length", r_byte.size(), 32'd4);
    if (r_byte.size() == 4) begin
      chk(req, "resp byte0", {24'd0, r_byte[0]}, {24'd0, cmd | 8'h80});
      chk(req, "resp byte1", {24'd0, r_byte[1]}, 32'd0);
      chk(req, "resp count", {16'd0, r_byte[2], r_byte[3]}, {16'd0, cnt});
      chk("R5", "resp framing", {28'd0, r_sop[0], r_sop[3], r_eop[0], r_eop[3]}, 32'b1001);
    end
    r_byte = {}; r_sop = {}; r_eop = {};
  endtask

  task automatic expect_writes(string req, logic [31:0] base, int n);
    chk(req, "write count", w_addr.size(), n);
    for (int i = 0; i < n && i < w_addr.size(); i++) begin
      logic [31:0] a = base + 32'(i);
      chk("R3", "word address", w_addr[i], {a[31:2], 2'b00});
      chk("R3", "byte enable", {28'd0, w_be[i]}, 32'd1 << a[1:0]);
      chk(req, "lane data", {24'd0, w_data[i][8*a[1:0] +: 8]}, {24'd0, pay_q[i]});
    end
    w_addr = {}; w_be = {}; w_data = {};
  endtask

  task automatic t_reset();
    chk("R1", "reset in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "reset bus_write", {31'd0, bus_write}, 32'd0);
  endtask

  task automatic t_basic_write();
    wait_cfg = 0; rdy_mode = 0;
    build_hdr(8'h00, 8'h00, 16'd5, 32'h1000_2001);
    add_payload(5, 8'h3C);
    send_pkt(1, 1);
    expect_resp("R2", 8'h00, 16'd5);
    expect_writes("R2", 32'h1000_2001, 5);
  endtask

  task automatic t_stalled_write();
    wait_cfg = 2; rdy_mode = 1;
    build_hdr(8'h00, 8'hA5, 16'd6, 32'h0000_80FE);
    add_payload(6, 8'h91);
    send_pkt(1, 1);
    expect_resp("R4", 8'h00, 16'd6);
    expect_writes("R1", 32'h0000_80FE, 6);
  endtask

  task automatic t_short_packet();
    wait_cfg = 1; rdy_mode = 0;
    build_hdr(8'h00, 8'h00, 16'd6, 32'h4000_0010);
    add_payload(3, 8'h07);
    send_pkt(1, 1);
    expect_resp("R6", 8'h00, 16'd3);
    expect_writes("R6", 32'h4000_0010, 3);
  endtask

  task automatic t_header_cut();
    wait_cfg = 0; rdy_mode = 0;
    pkt_q = {8'h00, 8'h00, 8'h00, 8'h04, 8'h12};
    send_pkt(1, 1);
    expect_resp("R6", 8'h00, 16'd0);
    chk("R6", "no write on cut header", w_addr.size(), 32'd0);
  endtask

  task automatic t_excess_payload();
    wait_cfg = 0; rdy_mode = 1;
    build_hdr(8'h00, 8'h00, 16'd2, 32'h2000_0003);
    add_payload(5, 8'hC0);
    send_pkt(1, 1);
    expect_resp("R7", 8'h00, 16'd2);
    expect_writes("R7", 32'h2000_0003, 2);
  endtask

  task automatic t_unknown_op();
    wait_cfg = 0; rdy_mode = 0;
    build_hdr(8'h07, 8'h00, 16'd4, 32'h0000_1000);
    add_payload(4, 8'h11);
    send_pkt(1, 1);
    expect_resp("R8", 8'h07, 16'd0);
    chk("R8", "no bus write", w_addr.size(), 32'd0);
  endtask

  task automatic t_sop_restart();
    wait_cfg = 0; rdy_mode = 0;
    pkt_q = {8'h55, 8'h66, 8'h77};
    send_pkt(1, 0);
    build_hdr(8'h00, 8'h00, 16'd1, 32'h0000_0042);
    add_payload(1, 8'hE7);
    send_pkt(1, 1);
    expect_resp("R10", 8'h00, 16'd1);
    expect_writes("R10", 32'h0000_0042, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_write();
    t_stalled_write();
    t_short_packet();
    t_header_cut();
    t_excess_payload();
    t_unknown_op();
    t_sop_restart();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule